// File: doc/BRIEF.md
# Message Signaled Interrupt Receiver

This block sits at the end of a memory-mapped write path and turns message writes into interrupt requests. The address window is split into fixed-size pages, one per interrupt file. A word-aligned write to the first word of a page is a doorbell. Its data is taken as an interrupt identity. When that identity is valid, the block raises a one-cycle set-pending strobe carrying the page and the identity.

Every accepted write also raises a one-cycle update strobe for its page. This tells the downstream interrupt file to re-evaluate its output line. Arbitration among pending identities belongs to that downstream logic.

Reads are answered with a one-cycle response carrying zero data. Misaligned accesses and accesses past the end of the window have no effect and raise a one-cycle error pulse. All outputs are registered and appear one cycle after the request.

Top module: `msir_top`

## Requirements
- R1: After reset, set_valid, upd_valid, rd_resp_valid and err are all low.
- R2: A write with wr_addr[1:0] = 0, wr_addr below NUM_PAGES * 2^PAGE_SHIFT, wr_addr[PAGE_SHIFT-1:0] = 0 and wr_data in 1..NUM_IDS-1 produces set_valid in the next cycle. In that cycle set_page = wr_addr >> PAGE_SHIFT and set_id = wr_data.
- R3: An aligned, in-window write at any non-zero offset inside a page, offset 0x4 included, produces no set_valid.
- R4: A doorbell write whose 32-bit data is zero, or is NUM_IDS or above, produces no set_valid. The comparison uses all 32 data bits, so upper bits cannot alias into a small identity.
- R5: A write or read with wr_addr[1:0] or rd_addr[1:0] not zero raises err for one cycle in the next cycle. A misaligned write produces neither set_valid nor upd_valid.
- R6: A write or read at an address of NUM_PAGES * 2^PAGE_SHIFT or above raises err in the next cycle. Such a write produces neither set_valid nor upd_valid.
- R7: Every aligned, in-window write, whatever its offset or data, produces upd_valid in the next cycle with upd_page = wr_addr >> PAGE_SHIFT.
- R8: Every read request produces rd_resp_valid in the next cycle with rd_data equal to zero, whether its address is valid or not.
- R9: All output strobes last one cycle. A cycle with no request leaves set_valid, upd_valid, rd_resp_valid and err low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | Write request |
| wr_addr | input | ADDR_W | Write byte address within the window |
| wr_data | input | 32 | Write data (interrupt identity for doorbells) |
| rd_valid | input | 1 | Read request |
| rd_addr | input | ADDR_W | Read byte address within the window |
| set_valid | output | 1 | Set-pending strobe |
| set_page | output | PAGE_W | Page (interrupt file) of the set-pending strobe |
| set_id | output | ID_W | Identity to mark pending |
| upd_valid | output | 1 | Page re-evaluation strobe |
| upd_page | output | PAGE_W | Page to re-evaluate |
| rd_resp_valid | output | 1 | Read response strobe |
| rd_data | output | 32 | Read response data |
| err | output | 1 | Access error pulse |

## Verification
The write sweep covers every page, including one page past the window, crossed with offsets 0, 4, 8, the last word of a page and the three misaligned byte offsets. Each address is paired with data values from zero through the top identity and past it, plus values whose low bits form a valid identity while their upper bits are set. This separates the doorbell word from other words, valid identities from dropped ones, and alignment errors from range errors. A read sweep over the same addresses, reads issued together with writes, and idle cycles between requests show that read responses stay zero and that no strobe outlasts its cycle.

// File: rtl/msir_pkg.sv
package msir_pkg;
  localparam int WORD_W = 32;

  typedef enum logic [1:0] {
    ACC_DOORBELL   = 2'd0,
    ACC_INERT      = 2'd1,
    ACC_MISALIGNED = 2'd2,
    ACC_OUTSIDE    = 2'd3
  } acc_class_e;
endpackage

// File: rtl/msir_decode.sv
module msir_decode
  import msir_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int PAGE_SHIFT = 12,
  parameter int NUM_PAGES  = 4
) (
  input  logic [ADDR_W-1:0] addr,
  output acc_class_e        cls
);
  localparam logic [ADDR_W:0] WIN_END = (ADDR_W+1)'(NUM_PAGES) << PAGE_SHIFT;

  function automatic acc_class_e classify(input logic [ADDR_W-1:0] a);
    if (a[1:0] != 2'b00)                return ACC_MISALIGNED;
    if ({1'b0, a} >= WIN_END)           return ACC_OUTSIDE;
    if (a[PAGE_SHIFT-1:0] == '0)        return ACC_DOORBELL;
    return ACC_INERT;
  endfunction

  assign cls = classify(addr);
endmodule

// File: rtl/msir_wr_stage.sv
module msir_wr_stage
  import msir_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int PAGE_SHIFT = 12,
  parameter int NUM_IDS    = 64,
  parameter int PAGE_W     = 2,
  parameter int ID_W       = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  acc_class_e        cls,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] data,
  output logic              set_valid,
  output logic [ID_W-1:0]   set_id,
  output logic              upd_valid,
  output logic [PAGE_W-1:0] page,
  output logic              wr_err
);
  function automatic logic [PAGE_W-1:0] page_of(input logic [ADDR_W-1:0] a);
    logic [ADDR_W-1:0] sh;
    sh = a >> PAGE_SHIFT;
    return sh[PAGE_W-1:0];
  endfunction

  function automatic logic id_in_range(input logic [WORD_W-1:0] d);
    return (d != '0) && (d < WORD_W'(NUM_IDS));
  endfunction

  logic wr_accept, wr_reject, id_ok, ring_fire;
  assign wr_accept = wr_valid && (cls == ACC_DOORBELL || cls == ACC_INERT);
  assign wr_reject = wr_valid && !wr_accept;
  assign id_ok     = id_in_range(data);
  assign ring_fire = wr_accept && (cls == ACC_DOORBELL) && id_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      set_valid <= 1'b0;
      set_id    <= '0;
      upd_valid <= 1'b0;
      page      <= '0;
      wr_err    <= 1'b0;
    end else begin
      set_valid <= ring_fire;
      upd_valid <= wr_accept;
      wr_err    <= wr_reject;
      if (wr_accept) page   <= page_of(addr);
      if (ring_fire) set_id <= data[ID_W-1:0];
    end
  end
endmodule

// File: rtl/msir_rd_stage.sv
module msir_rd_stage
  import msir_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_valid,
  input  acc_class_e        cls,
  output logic              rd_resp_valid,
  output logic [WORD_W-1:0] rd_data,
  output logic              rd_err
);
  logic rd_bad;
  assign rd_bad  = rd_valid && (cls == ACC_MISALIGNED || cls == ACC_OUTSIDE);
  assign rd_data = '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_resp_valid <= 1'b0;
      rd_err        <= 1'b0;
    end else begin
      rd_resp_valid <= rd_valid;
      rd_err        <= rd_bad;
    end
  end
endmodule

// File: rtl/msir_top.sv
module msir_top
  import msir_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int PAGE_SHIFT = 12,
  parameter int NUM_PAGES  = 4,
  parameter int NUM_IDS    = 64,
  localparam int PAGE_W    = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1,
  localparam int ID_W      = $clog2(NUM_IDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic              rd_valid,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              set_valid,
  output logic [PAGE_W-1:0] set_page,
  output logic [ID_W-1:0]   set_id,
  output logic              upd_valid,
  output logic [PAGE_W-1:0] upd_page,
  output logic              rd_resp_valid,
  output logic [31:0]       rd_data,
  output logic              err
);
  acc_class_e        wr_cls, rd_cls;
  logic [PAGE_W-1:0] page_q;
  logic              wr_err, rd_err;

  msir_decode #(.ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT), .NUM_PAGES(NUM_PAGES))
    u_wr_dec (.addr(wr_addr), .cls(wr_cls));

  msir_decode #(.ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT), .NUM_PAGES(NUM_PAGES))
    u_rd_dec (.addr(rd_addr), .cls(rd_cls));

  msir_wr_stage #(
    .ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT), .NUM_IDS(NUM_IDS),
    .PAGE_W(PAGE_W), .ID_W(ID_W)
  ) u_wr (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .cls(wr_cls),
    .addr(wr_addr), .data(wr_data), .set_valid(set_valid), .set_id(set_id),
    .upd_valid(upd_valid), .page(page_q), .wr_err(wr_err)
  );

  msir_rd_stage u_rd (
    .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .cls(rd_cls),
    .rd_resp_valid(rd_resp_valid), .rd_data(rd_data), .rd_err(rd_err)
  );

  assign set_page = page_q;
  assign upd_page = page_q;
  assign err      = wr_err | rd_err;
endmodule

// File: rtl/msir_checker.sv
module msir_checker #(
  parameter int ADDR_W     = 16,
  parameter int PAGE_SHIFT = 12,
  parameter int NUM_PAGES  = 4,
  parameter int NUM_IDS    = 64,
  parameter int PAGE_W     = 2,
  parameter int ID_W       = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_valid,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [31:0]       wr_data,
  input logic              rd_valid,
  input logic              set_valid,
  input logic [PAGE_W-1:0] set_page,
  input logic [ID_W-1:0]   set_id,
  input logic              upd_valid,
  input logic [PAGE_W-1:0] upd_page,
  input logic              rd_resp_valid,
  input logic              err
);
  localparam logic [ADDR_W:0] WIN_END = (ADDR_W+1)'(NUM_PAGES) << PAGE_SHIFT;

  AST_SET_HAS_UPD: assert property (@(posedge clk) disable iff (!rst_n)
    set_valid |-> upd_valid && (upd_page == set_page)) else $error("AST_SET_HAS_UPD"); // R7
  AST_SET_ID_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    set_valid |-> (set_id != '0) && (32'(set_id) < 32'(NUM_IDS))) else $error("AST_SET_ID_NONZERO"); // R4
  AST_ZERO_DATA_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && (wr_data == '0) |=> !set_valid) else $error("AST_ZERO_DATA_DROPPED"); // R4
  AST_OFFSET_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && (wr_addr[PAGE_SHIFT-1:0] != '0) |=> !set_valid) else $error("AST_OFFSET_NO_SET"); // R3
  AST_MISALIGN_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && (wr_addr[1:0] != 2'b00) |=> err && !upd_valid && !set_valid) else $error("AST_MISALIGN_ERR"); // R5
  AST_OUTSIDE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && ({1'b0, wr_addr} >= WIN_END) |=> err && !upd_valid) else $error("AST_OUTSIDE_ERR"); // R6
  AST_RD_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> rd_resp_valid) else $error("AST_RD_RESP"); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid && !rd_valid |=> !set_valid && !upd_valid && !rd_resp_valid && !err) else $error("AST_IDLE_QUIET"); // R9
endmodule

bind msir_top msir_checker #(
  .ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT), .NUM_PAGES(NUM_PAGES),
  .NUM_IDS(NUM_IDS), .PAGE_W(PAGE_W), .ID_W(ID_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
  .wr_data(wr_data), .rd_valid(rd_valid), .set_valid(set_valid),
  .set_page(set_page), .set_id(set_id), .upd_valid(upd_valid),
  .upd_page(upd_page), .rd_resp_valid(rd_resp_valid), .err(err)
);

// File: tb/msir_top_bench.sv
module msir_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int PAGES = 4;
  localparam int IDS = 64;
  localparam int PW = 2;
  localparam int IW = 6;
  localparam longint WIN = 64'(PAGES) * 4096;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_valid = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [31:0]   wr_data = '0;
  logic          rd_valid = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic          set_valid, upd_valid, rd_resp_valid, err;
  logic [PW-1:0] set_page, upd_page;
  logic [IW-1:0] set_id;
  logic [31:0]   rd_data;

  int n_checks = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  msir_top #(.ADDR_W(AW), .PAGE_SHIFT(12), .NUM_PAGES(PAGES), .NUM_IDS(IDS)) u_msir_top (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_valid(rd_valid), .rd_addr(rd_addr),
    .set_valid(set_valid), .set_page(set_page), .set_id(set_id),
    .upd_valid(upd_valid), .upd_page(upd_page), .rd_resp_valid(rd_resp_valid),
    .rd_data(rd_data), .err(err)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit bad_addr(input longint a);
    return (a % 4 != 0) || (a >= WIN);
  endfunction

  // drive one cycle of requests, then sample the registered response
  task automatic access(input bit wv, input longint wa, input longint wd,
                        input bit rv, input longint ra);
    bit ok_w, e_upd, e_set, e_err;
    wr_valid = wv; wr_addr = AW'(wa); wr_data = 32'(wd);
    rd_valid = rv; rd_addr = AW'(ra);
    ok_w  = wv && !bad_addr(wa);
    e_upd = ok_w;
    e_set = ok_w && (wa % 4096 == 0) && (wd != 0) && (wd < IDS);
    e_err = (wv && bad_addr(wa)) || (rv && bad_addr(ra));
    @(negedge clk);
    wr_valid = 1'b0; rd_valid = 1'b0;
    // R2 R3 R4: set strobe only for doorbell word with valid identity
    check(set_valid == e_set, "R2/R3/R4", $sformatf("set_valid addr=%0h data=%0h", wa, wd), set_valid, e_set);
    if (e_set) begin
      check(set_page == PW'(wa / 4096), "R2", "set_page", set_page, wa / 4096);
      check(set_id == IW'(wd), "R2", "set_id", set_id, wd);
    end
    // R7: update for every accepted write
    check(upd_valid == e_upd, "R7", $sformatf("upd_valid addr=%0h", wa), upd_valid, e_upd);
    if (e_upd) check(upd_page == PW'(wa / 4096), "R7", "upd_page", upd_page, wa / 4096);
    // R5 R6: error pulse
    check(err == e_err, "R5/R6", $sformatf("err waddr=%0h raddr=%0h", wa, ra), err, e_err);
    // R8: read response with zero data
    check(rd_resp_valid == rv, "R8", "rd_resp_valid", rd_resp_valid, rv);
    if (rv) check(rd_data == 32'd0, "R8", "rd_data", rd_data, 0);
  endtask

  task automatic idle_check();
    @(negedge clk);
    // R9: strobes are single-cycle
    check(!set_valid && !upd_valid && !rd_resp_valid && !err, "R9", "strobe after idle",
          {set_valid, upd_valid, rd_resp_valid, err}, 0);
  endtask

  initial begin
    longint offs [8] = '{0, 4, 8, 32'hFFC, 1, 2, 3, 12};
    longint datas [11] = '{0, 1, 2, 31, 62, 63, 64, 65, 32'h0040_0001, 32'hFFFF_FFFF, 32'h8000_0000};
    #(CLK_PERIOD * 3);
    @(negedge clk);
    // R1: reset state
    check(!set_valid && !upd_valid && !rd_resp_valid && !err, "R1", "outputs in reset",
          {set_valid, upd_valid, rd_resp_valid, err}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!set_valid && !upd_valid && !rd_resp_valid && !err, "R1", "outputs after reset",
          {set_valid, upd_valid, rd_resp_valid, err}, 0);

    for (int p = 0; p <= PAGES; p++)
      for (int o = 0; o < 8; o++)
        for (int d = 0; d < 11; d++)
          access(1'b1, longint'(p) * 4096 + offs[o], datas[d], 1'b0, 0);

    // R6: top of the address space and last word of the window
    access(1'b1, 64'hFFFC, 5, 1'b0, 0);
    access(1'b1, WIN - 4, 7, 1'b0, 0);
    access(1'b1, 64'hFFFF, 5, 1'b0, 0);

    // R8: read sweep over valid and invalid addresses
    for (int p = 0; p <= PAGES; p++)
      for (int o = 0; o < 8; o++)
        access(1'b0, 0, 0, 1'b1, longint'(p) * 4096 + offs[o]);

    // reads and writes together
    access(1'b1, 32'h2000, 9, 1'b1, 32'h1003);
    access(1'b1, 32'h3001, 9, 1'b1, 32'h0000);
    access(1'b1, 32'h1000, 63, 1'b1, 32'h5000);

    // R9: back-to-back doorbells then idle
    access(1'b1, 32'h0000, 1, 1'b0, 0);
    access(1'b1, 32'h3000, 2, 1'b0, 0);
    idle_check();
    access(1'b0, 0, 0, 1'b1, 4);
    idle_check();

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule